// File: doc/BRIEF.md
# I/O Bus Cycle Target with Wait-State Ready

This block sits on the slave side of a 64-bit processor bus that uses an address strobe and a ready handshake. It samples the cycle-definition lines on the clock edge where the strobe is seen. It then sorts the cycle into one of five kinds. Memory cycles are left alone. I/O data reads and writes are served from a small bank of 64-bit registers that sits at a quadword-aligned window of I/O space. The I/O code-read encoding is treated as an interrupt acknowledge and is answered with a vector byte. The I/O code-write encoding is treated as a special cycle and is reported on a one-clock flag.

Every claimed cycle ends with a single-clock ready pulse. The pulse comes after a fixed number of wait states set by a parameter. While a cycle is outstanding, the block takes no new strobe. One of the bank registers also holds the interrupt vector, so software programs the vector with an ordinary I/O write.

Top module: `iobt_target`

## Requirements
- R1: A strobe whose cycle has `cyc_mem`=1 is a memory cycle. It produces no ready pulse and no special flag, and it changes no register.
- R2: An I/O data read (`cyc_data`=1, `cyc_mem`=0, `cyc_wr`=0) whose quadword address is `IO_BASE`+n, with n below `NREGS`, drives register n on `rdata` during its ready cycle. `rdata` is all zero in every cycle without ready.
- R3: An I/O data write (`cyc_data`=1, `cyc_mem`=0, `cyc_wr`=1) to register n replaces byte k (bits 8k+7..8k) with the same byte of `wdata` for each `lane_en` bit k that is set. It leaves the other bytes unchanged. `wdata` is taken in the ready cycle.
- R4: The encoding `cyc_data`=0, `cyc_mem`=0, `cyc_wr`=0 is an interrupt acknowledge. Its ready cycle drives byte 0 of register `VEC_IDX` on `rdata[7:0]` and zero on `rdata[63:8]`, and no register changes.
- R5: The encoding `cyc_data`=0, `cyc_mem`=0, `cyc_wr`=1 is a special cycle. In its ready cycle, and only then, `spec_pulse` is high and `spec_lanes` carries the `lane_en` value sampled with the strobe. No register changes.
- R6: When a strobe is sampled at a clock edge, `ready` goes high exactly `WAIT` clocks after that edge and stays high for exactly one clock.
- R7: A strobe that arrives while a cycle is outstanding is ignored. This includes the ready cycle itself. It yields no extra ready and no register write.
- R8: An I/O data read or write whose quadword address lies outside the register window is not claimed. It yields no ready and changes no register.
- R9: After reset, `ready` and `spec_pulse` are low, `rdata` and `spec_lanes` are zero, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Address strobe, active high, starts a cycle |
| addr | input | 29 | Quadword address (byte address bits 31..3) |
| lane_en | input | 8 | Byte-lane enables, active high, bit k selects byte k |
| cyc_data | input | 1 | Cycle definition: 1 data, 0 code |
| cyc_mem | input | 1 | Cycle definition: 1 memory, 0 I/O |
| cyc_wr | input | 1 | Cycle definition: 1 write, 0 read |
| wdata | input | 64 | Write data, taken in the ready cycle |
| rdata | output | 64 | Read or vector data, valid in the ready cycle, zero otherwise |
| ready | output | 1 | One-clock cycle completion |
| spec_pulse | output | 1 | One-clock special-cycle flag |
| spec_lanes | output | 8 | Byte enables of the special cycle, valid with `spec_pulse` |

## Verification
Assertions check on every cycle that ready lasts one clock and lands exactly `WAIT` clocks after acceptance. They also check that a strobe for a memory cycle leaves the sequencer idle, that the captured cycle stays frozen while the cycle is outstanding, and that the registers hold still whenever no write commits. The bench scenarios cover the rest. These are the data values returned for reads and for the vector, the byte-lane merging on partial writes, the lane pattern carried by the special flag, and the fact that cycles outside the window or overlapping an outstanding cycle leave every register as it was.

// File: rtl/iobt_pkg.sv
package iobt_pkg;

    localparam int DATA_W = 64;
    localparam int LANES  = DATA_W / 8;
    localparam int ADDR_W = 29;

    typedef enum logic [2:0] {
        CK_MEM  = 3'd0,
        CK_IORD = 3'd1,
        CK_IOWR = 3'd2,
        CK_INTA = 3'd3,
        CK_SPEC = 3'd4
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e          kind;
        logic [LANES-1:0]   lanes;
    } cyc_info_t;

    // Map the three cycle-definition lines to a cycle kind.
    function automatic cyc_kind_e classify(logic is_data, logic is_mem, logic is_wr);
        if (is_mem)
            return CK_MEM;
        case ({is_data, is_wr})
            2'b10:   return CK_IORD;
            2'b11:   return CK_IOWR;
            2'b00:   return CK_INTA;
            default: return CK_SPEC;
        endcase
    endfunction

endpackage

// File: rtl/iobt_seq.sv
module iobt_seq
    import iobt_pkg::*;
#(
    parameter int                WAIT    = 2,
    parameter int                IDX_W   = 2,
    parameter logic [ADDR_W-1:0] IO_BASE = 29'h40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [LANES-1:0]     lane_en,
    input  logic                 cyc_data,
    input  logic                 cyc_mem,
    input  logic                 cyc_wr,
    output logic                 ready,
    output cyc_info_t            cur,
    output logic [IDX_W-1:0]     idx
);
    localparam int CW = 3;

    cyc_kind_e    kind_now;
    logic         in_window;
    logic         claim;
    logic         accept;
    logic         busy;
    logic [CW-1:0] cnt;

    always_comb begin
        kind_now  = classify(cyc_data, cyc_mem, cyc_wr);
        in_window = (addr[ADDR_W-1:IDX_W] == IO_BASE[ADDR_W-1:IDX_W]);
        claim     = (kind_now == CK_INTA) || (kind_now == CK_SPEC) ||
                    (((kind_now == CK_IORD) || (kind_now == CK_IOWR)) && in_window);
        accept    = strobe && !busy && !ready && claim;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            ready <= 1'b0;
            cnt   <= '0;
            cur   <= '{kind: CK_MEM, lanes: '0};
            idx   <= '0;
        end else begin
            ready <= 1'b0;
            if (accept) begin
                cur <= '{kind: kind_now, lanes: lane_en};
                idx <= addr[IDX_W-1:0];
                if (WAIT == 0) begin
                    ready <= 1'b1;
                end else begin
                    busy <= 1'b1;
                    cnt  <= CW'(WAIT - 1);
                end
            end else if (busy) begin
                if (cnt == '0) begin
                    busy  <= 1'b0;
                    ready <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // Checker counter: clocks since the last accepted strobe.
    logic [3:0] gap;
    always_ff @(posedge clk) begin
        if (rst)
            gap <= '0;
        else if (accept)
            gap <= '0;
        else if (gap != 4'hF)
            gap <= gap + 1'b1;
    end

    a_r6_ready_one_clock: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    a_r6_wait_count: assert property (@(posedge clk) disable iff (rst)
        ready |-> (gap == 4'(WAIT)));

    a_r1_memory_unclaimed: assert property (@(posedge clk) disable iff (rst)
        (strobe && cyc_mem && !busy && !ready) |=> (!busy && !ready));

    a_r7_frozen_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(cur) && $stable(idx)));

endmodule

// File: rtl/iobt_regbank.sv
module iobt_regbank
    import iobt_pkg::*;
#(
    parameter int NREGS   = 4,
    parameter int IDX_W   = 2,
    parameter int VEC_IDX = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [LANES-1:0]   lanes,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_word,
    output logic [7:0]         vec_byte
);
    logic [NREGS-1:0][DATA_W-1:0] bank;

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst)
                    bank[r][8*b +: 8] <= '0;
                else if (wr_en && (idx == IDX_W'(r)) && lanes[b])
                    bank[r][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    always_comb begin
        rd_word  = bank[idx];
        vec_byte = bank[VEC_IDX][7:0];
    end

    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(bank));

endmodule

// File: rtl/iobt_target.sv
module iobt_target
    import iobt_pkg::*;
#(
    parameter int                WAIT    = 2,
    parameter int                NREGS   = 4,
    parameter int                VEC_IDX = 3,
    parameter logic [ADDR_W-1:0] IO_BASE = 29'h40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strobe,
    input  logic [28:0]        addr,
    input  logic [7:0]         lane_en,
    input  logic               cyc_data,
    input  logic               cyc_mem,
    input  logic               cyc_wr,
    input  logic [63:0]        wdata,
    output logic [63:0]        rdata,
    output logic               ready,
    output logic               spec_pulse,
    output logic [7:0]         spec_lanes
);
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

    cyc_info_t          cur;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  rd_word;
    logic [7:0]         vec_byte;
    logic               wr_en;

    iobt_seq #(.WAIT(WAIT), .IDX_W(IDX_W), .IO_BASE(IO_BASE)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .addr     (addr),
        .lane_en  (lane_en),
        .cyc_data (cyc_data),
        .cyc_mem  (cyc_mem),
        .cyc_wr   (cyc_wr),
        .ready    (ready),
        .cur      (cur),
        .idx      (idx)
    );

    assign wr_en = ready && (cur.kind == CK_IOWR);

    iobt_regbank #(.NREGS(NREGS), .IDX_W(IDX_W), .VEC_IDX(VEC_IDX)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .idx      (idx),
        .lanes    (cur.lanes),
        .wdata    (wdata),
        .rd_word  (rd_word),
        .vec_byte (vec_byte)
    );

    always_comb begin
        rdata      = '0;
        spec_pulse = 1'b0;
        spec_lanes = '0;
        if (ready) begin
            case (cur.kind)
                CK_IORD: rdata = rd_word;
                CK_INTA: rdata = {{(DATA_W-8){1'b0}}, vec_byte};
                CK_SPEC: begin
                    spec_pulse = 1'b1;
                    spec_lanes = cur.lanes;
                end
                default: ;
            endcase
        end
    end

    a_r5_flag_one_clock: assert property (@(posedge clk) disable iff (rst)
        spec_pulse |=> !spec_pulse);

endmodule

// File: tb/sim_iobt_target.sv
module sim_iobt_target;
    localparam int WAIT = 2;
    localparam logic [28:0] BASE = 29'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic [28:0] addr = '0;
    logic [7:0]  lane_en = '0;
    logic        cyc_data = 1'b0, cyc_mem = 1'b1, cyc_wr = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        ready, spec_pulse;
    logic [7:0]  spec_lanes;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    iobt_target #(.WAIT(WAIT), .IO_BASE(BASE)) u0 (
        .clk(clk), .rst(rst), .strobe(strobe), .addr(addr), .lane_en(lane_en),
        .cyc_data(cyc_data), .cyc_mem(cyc_mem), .cyc_wr(cyc_wr), .wdata(wdata),
        .rdata(rdata), .ready(ready), .spec_pulse(spec_pulse), .spec_lanes(spec_lanes)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle; reports ready latency (negedges after strobe), data and flags.
    task automatic bus_cycle(input logic dc, input logic mio, input logic wr,
                             input logic [28:0] a, input logic [7:0] be, input logic [63:0] wd,
                             output logic got, output int lat, output logic [63:0] rd,
                             output logic sp, output logic [7:0] spl, output logic rdy_after);
        got = 0; lat = 0; rd = '0; sp = 0; spl = '0;
        @(negedge clk);
        cyc_data = dc; cyc_mem = mio; cyc_wr = wr; addr = a; lane_en = be; wdata = wd;
        strobe = 1'b1;
        for (int i = 1; i <= WAIT + 6; i++) begin
            @(negedge clk);
            if (i == 1) strobe = 1'b0;
            if (ready) begin
                got = 1; lat = i; rd = rdata; sp = spec_pulse; spl = spec_lanes;
                break;
            end
        end
        @(negedge clk);
        rdy_after = ready | spec_pulse;
        cyc_mem = 1'b1; wdata = '0; lane_en = '0;
    endtask

    task automatic io_write(input int r, input logic [7:0] be, input logic [63:0] d);
        logic g, s, ra; int l; logic [63:0] x; logic [7:0] sl;
        bus_cycle(1, 0, 1, BASE + 29'(r), be, d, g, l, x, s, sl, ra);
        check(g, "R3 write claimed", 64'(g), 64'd1);
    endtask

    task automatic io_read(input int r, output logic [63:0] v);
        logic g, s, ra; int l; logic [7:0] sl;
        bus_cycle(1, 0, 0, BASE + 29'(r), 8'hFF, '0, g, l, v, s, sl, ra);
        check(g, "R2 read claimed", 64'(g), 64'd1);
    endtask

    task automatic t_reset();
        logic [63:0] v;
        check(!ready && !spec_pulse, "R9 reset flags", {62'b0, ready, spec_pulse}, 64'd0);
        check(rdata == 64'd0 && spec_lanes == 8'd0, "R9 reset data", rdata, 64'd0);
        io_read(2, v);
        check(v == 64'd0, "R9 register cleared", v, 64'd0);
    endtask

    task automatic t_read_write();
        logic g, s, ra; int l; logic [63:0] v; logic [7:0] sl;
        io_write(1, 8'hFF, 64'hDEAD_BEEF_0123_4567);
        bus_cycle(1, 0, 0, BASE + 29'd1, 8'hFF, '0, g, l, v, s, sl, ra);
        check(v == 64'hDEAD_BEEF_0123_4567, "R2 read data", v, 64'hDEAD_BEEF_0123_4567);
        check(l == WAIT + 1, "R6 ready latency", 64'(l), 64'(WAIT + 1));
        check(!ra, "R6 ready one clock", 64'(ra), 64'd0);
        io_write(1, 8'h0F, 64'hAAAA_BBBB_CCCC_DDDD);
        io_read(1, v);
        check(v == 64'hDEAD_BEEF_CCCC_DDDD, "R3 low lanes merge", v, 64'hDEAD_BEEF_CCCC_DDDD);
        io_write(1, 8'h81, 64'h1100_0000_0000_0022);
        io_read(1, v);
        check(v == 64'h11AD_BEEF_CCCC_DD22, "R3 sparse lanes merge", v, 64'h11AD_BEEF_CCCC_DD22);
        check(rdata == 64'd0, "R2 rdata zero when idle", rdata, 64'd0);
    endtask

    task automatic t_intack();
        logic g, s, ra; int l; logic [63:0] v; logic [7:0] sl;
        io_write(3, 8'hFF, 64'h1122_3344_5566_77A5);
        bus_cycle(0, 0, 0, 29'h1234, 8'h01, '0, g, l, v, s, sl, ra);
        check(g && l == WAIT + 1, "R4 intack ready", 64'(l), 64'(WAIT + 1));
        check(v == 64'h0000_0000_0000_00A5, "R4 vector byte", v, 64'hA5);
        io_read(3, v);
        check(v == 64'h1122_3344_5566_77A5, "R4 vector reg unchanged", v, 64'h1122_3344_5566_77A5);
    endtask

    task automatic t_special();
        logic g, s, ra; int l; logic [63:0] v; logic [7:0] sl;
        bus_cycle(0, 0, 1, BASE, 8'h5A, 64'hFFFF_FFFF_FFFF_FFFF, g, l, v, s, sl, ra);
        check(g && l == WAIT + 1, "R5 special ready", 64'(l), 64'(WAIT + 1));
        check(s && sl == 8'h5A, "R5 special flag lanes", {55'b0, s, sl}, {55'b0, 1'b1, 8'h5A});
        check(!ra, "R5 flag one clock", 64'(ra), 64'd0);
        io_read(0, v);
        check(v == 64'd0, "R5 no register write", v, 64'd0);
    endtask

    task automatic t_memory();
        logic g, s, ra; int l; logic [63:0] v; logic [7:0] sl;
        bus_cycle(1, 1, 1, BASE + 29'd1, 8'hFF, 64'h0, g, l, v, s, sl, ra);
        check(!g && !s, "R1 memory write unclaimed", 64'(g), 64'd0);
        bus_cycle(1, 1, 0, BASE + 29'd1, 8'hFF, 64'h0, g, l, v, s, sl, ra);
        check(!g, "R1 memory read unclaimed", 64'(g), 64'd0);
        io_read(1, v);
        check(v == 64'h11AD_BEEF_CCCC_DD22, "R1 register kept", v, 64'h11AD_BEEF_CCCC_DD22);
    endtask

    task automatic t_miss();
        logic g, s, ra; int l; logic [63:0] v; logic [7:0] sl;
        bus_cycle(1, 0, 1, BASE + 29'd4 + 29'd1, 8'hFF, 64'h0, g, l, v, s, sl, ra);
        check(!g, "R8 outside window write", 64'(g), 64'd0);
        bus_cycle(1, 0, 0, 29'h3F, 8'hFF, 64'h0, g, l, v, s, sl, ra);
        check(!g, "R8 outside window read", 64'(g), 64'd0);
        io_read(1, v);
        check(v == 64'h11AD_BEEF_CCCC_DD22, "R8 register kept", v, 64'h11AD_BEEF_CCCC_DD22);
    endtask

    task automatic t_overlap();
        int readies = 0;
        logic [63:0] v;
        @(negedge clk);
        cyc_data = 1; cyc_mem = 0; cyc_wr = 1; lane_en = 8'hFF; wdata = 64'h5555_6666_7777_8888;
        addr = BASE + 29'd2; strobe = 1'b1;
        @(negedge clk);
        if (ready) readies++;
        addr = BASE;            // second strobe while busy
        @(negedge clk);
        if (ready) readies++;
        strobe = 1'b0;
        for (int i = 0; i < WAIT + 8; i++) begin
            @(negedge clk);
            if (ready) begin
                readies++;
                strobe = 1'b1;  // strobe inside the ready cycle
                addr = BASE;
            end else begin
                strobe = 1'b0;
            end
        end
        cyc_mem = 1'b1; wdata = '0; lane_en = '0;
        check(readies == 1, "R7 single ready for overlapped strobes", 64'(readies), 64'd1);
        io_read(2, v);
        check(v == 64'h5555_6666_7777_8888, "R7 first cycle written", v, 64'h5555_6666_7777_8888);
        io_read(0, v);
        check(v == 64'd0, "R7 ignored strobes wrote nothing", v, 64'd0);
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_write();
        t_intack();
        t_special();
        t_memory();
        t_miss();
        t_overlap();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule